// File: doc/BRIEF.md
# Triggered Pipeline Window Capture

This block keeps a rolling history of per-channel samples, one word per clock holding every channel's 10-bit value side by side. Every sample goes into the history on every clock, whether or not a trigger is in flight. When a trigger-accept pulse arrives, the samples that were current one trigger-decision latency earlier are still in the history. The block copies a short run of consecutive history words around that aligned sample into a first-level readout FIFO. It puts a header word carrying a trigger sequence number in front of them.

A controller drains the FIFO through its own read strobe, at its own pace. Accepts that arrive while a window is being copied wait in a small pending queue. An accept that finds the queue full is lost and raises a sticky flag. A window that cannot fit whole in the FIFO is discarded entirely and counted.

Top module: `trig_window_capture`

## Requirements
- R1: Let k be the index of the sample presented on the same clock as an accepted trigger. The stored window holds samples k-LATENCY-WIN_LEN/2 up to k-LATENCY-WIN_LEN/2+WIN_LEN-1, oldest first, regardless of trigger or read activity in between.
- R2: A stored window is one header word followed by WIN_LEN data words. The header has bit NCH*SMP_W (the top bit) set to 1, the sequence number in bits [11:0], and zeros elsewhere. Data words have the top bit 0, and channel c sits in bits [c*SMP_W +: SMP_W].
- R3: Sequence numbers start at 0 after reset. They grow by one for every accept that enters the pending queue, including accepts whose window is later discarded, so a discarded window leaves a gap.
- R4: An accept enters the pending queue when fewer than two accepts are waiting at that clock. Otherwise it is lost, takes no sequence number, and sets the overflow flag, which stays set until reset.
- R5: A waiting window is started only if the FIFO has at least WIN_LEN+1 free words. Otherwise none of its words are written and the drop count increases by one, saturating at its maximum.
- R6: A read strobe while the FIFO is not empty returns the oldest word on the read data output with the valid flag high on the next clock. A read strobe while it is empty is ignored, and the valid flag stays low.
- R7: The empty flag is high exactly when the FIFO holds no words. The full flag is high exactly when it holds FIFO_DEPTH words.
- R8: After reset the FIFO is empty and not full, the overflow flag and the read valid flag are low, and the drop count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | NCH*SMP_W | One sample per channel, channel c in bits [c*SMP_W +: SMP_W] |
| trig_accept | input | 1 | Trigger accept, one accept per clock it is high |
| rd_en | input | 1 | Read strobe from the control side |
| rd_data | output | NCH*SMP_W+1 | FIFO word; top bit marks a header |
| rd_valid | output | 1 | rd_data holds a word read on the previous clock |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| trig_overflow | output | 1 | Sticky: an accept was lost because the pending queue was full |
| drop_count | output | DROP_W | Number of windows discarded for lack of FIFO room |

## Verification
The hardest situation to reach from the ports is an accept that is queued but then finds the FIFO too small for its whole window. Reaching it means holding off the reader and stacking windows until the remaining space falls below one window. The bench shrinks the FIFO to exactly six windows and fills it with spaced accepts while no reads occur. It then fires accepts against a full FIFO and against a FIFO with a single free word. It checks that the drop count moves, that nothing partial appears, and that later sequence numbers show the gaps. Back-to-back accept bursts of three and four reach the pending-queue limit.

// File: rtl/twc_pkg.sv
package twc_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_HDR  = 2'd1,
        CAP_DATA = 2'd2
    } cap_state_e;

    // Address bits for the history ring: it must still hold the oldest
    // sample of a window that waited behind a full pending queue.
    function automatic int hist_addr_bits(input int lat, input int win, input int pend);
        return $clog2(lat + win + (pend + 2) * (win + 2));
    endfunction

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/twc_history.sv
module twc_history #(
    parameter int WORD_W = 240,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] wr_data,
    output logic [AW-1:0]     wr_ptr,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] ring [DEPTH];

    // Written on every clock, independent of trigger traffic.
    always_ff @(posedge clk) begin
        ring[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_ptr <= '0;
        else     wr_ptr <= wr_ptr + AW'(1);
    end

    assign rd_data = ring[rd_addr];

endmodule

// File: rtl/twc_pending.sv
module twc_pending
    import twc_pkg::*;
#(
    parameter int ENT_W = 20,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ENT_W-1:0] push_data,
    output logic             push_ok,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic             valid
);
    localparam int PW = ptr_bits(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [ENT_W-1:0] slot [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign push_ok = (cnt < CW'(DEPTH));
    assign valid   = (cnt != '0);
    assign head    = slot[rp];

    always_ff @(posedge clk) begin
        if (push) slot[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R4
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0)); // R4
    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < CW'(DEPTH))); // R4

endmodule

// File: rtl/twc_fifo.sv
module twc_fifo
    import twc_pkg::*;
#(
    parameter int WORD_W = 241,
    parameter int DEPTH  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = ptr_bits(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic              do_rd;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (do_rd) rd_data <= mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            level    <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en) wptr <= step(wptr);
            if (do_rd) rptr <= step(rptr);
            rd_valid <= do_rd;
            case ({wr_en, do_rd})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full); // R5
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)); // R7

endmodule

// File: rtl/trig_window_capture.sv
module trig_window_capture
    import twc_pkg::*;
#(
    parameter int NCH        = 24,
    parameter int SMP_W      = 10,
    parameter int LATENCY    = 212,
    parameter int WIN_LEN    = 4,
    parameter int FIFO_DEPTH = 32,
    parameter int PEND_DEPTH = 2,
    parameter int SEQ_W      = 12,
    parameter int DROP_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH*SMP_W-1:0]   smp_data,
    input  logic                   trig_accept,
    input  logic                   rd_en,
    output logic [NCH*SMP_W:0]     rd_data,
    output logic                   rd_valid,
    output logic                   fifo_empty,
    output logic                   fifo_full,
    output logic                   trig_overflow,
    output logic [DROP_W-1:0]      drop_count
);
    localparam int WORD_W = NCH * SMP_W;
    localparam int OUT_W  = WORD_W + 1;
    localparam int PRE    = WIN_LEN / 2;
    localparam int AW     = hist_addr_bits(LATENCY, WIN_LEN, PEND_DEPTH);
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
    localparam int J_W    = $clog2(WIN_LEN + 1);
    localparam int ENT_W  = AW + SEQ_W;

    typedef struct packed {
        logic [AW-1:0]    start;
        logic [SEQ_W-1:0] seq;
    } pend_t;

    // history ring
    logic [AW-1:0]     hist_wptr, hist_raddr;
    logic [WORD_W-1:0] hist_rdata;

    twc_history #(.WORD_W(WORD_W), .AW(AW)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_data (smp_data),
        .wr_ptr  (hist_wptr),
        .rd_addr (hist_raddr),
        .rd_data (hist_rdata)
    );

    // pending accepts
    logic             push, push_ok, pop, pend_valid;
    logic [SEQ_W-1:0] seq_ctr;
    pend_t            new_ent, head_ent, cur;
    logic [ENT_W-1:0] head_raw;

    assign push          = trig_accept && push_ok;
    assign new_ent.start = hist_wptr - AW'(LATENCY + PRE);
    assign new_ent.seq   = seq_ctr;
    assign head_ent      = pend_t'(head_raw);

    twc_pending #(.ENT_W(ENT_W), .DEPTH(PEND_DEPTH)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (ENT_W'(new_ent)),
        .push_ok   (push_ok),
        .pop       (pop),
        .head      (head_raw),
        .valid     (pend_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)       seq_ctr <= '0;
        else if (push) seq_ctr <= seq_ctr + SEQ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                            trig_overflow <= 1'b0;
        else if (trig_accept && !push_ok)   trig_overflow <= 1'b1;
    end

    // readout FIFO
    logic              fifo_wr;
    logic [OUT_W-1:0]  fifo_wdata;
    logic [LVL_W-1:0]  level;
    logic              room;

    twc_fifo #(.WORD_W(OUT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fifo_wr),
        .wr_data  (fifo_wdata),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .level    (level)
    );

    assign room = (int'(level) + WIN_LEN + 1 <= FIFO_DEPTH);

    // copy sequencer
    cap_state_e     state;
    logic [J_W-1:0] j;

    assign pop        = (state == CAP_IDLE) && pend_valid;
    assign fifo_wr    = (state != CAP_IDLE);
    assign hist_raddr = cur.start + AW'(j);

    always_comb begin
        if (state == CAP_HDR)
            fifo_wdata = {1'b1, {(WORD_W - SEQ_W){1'b0}}, cur.seq};
        else
            fifo_wdata = {1'b0, hist_rdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CAP_IDLE;
            j          <= '0;
            cur        <= '0;
            drop_count <= '0;
        end else begin
            case (state)
                CAP_IDLE: begin
                    if (pend_valid) begin
                        if (room) begin
                            cur   <= head_ent;
                            state <= CAP_HDR;
                        end else if (drop_count != {DROP_W{1'b1}}) begin
                            drop_count <= drop_count + DROP_W'(1);
                        end
                    end
                end
                CAP_HDR: begin
                    j     <= '0;
                    state <= CAP_DATA;
                end
                CAP_DATA: begin
                    j <= j + J_W'(1);
                    if (j == J_W'(WIN_LEN - 1)) state <= CAP_IDLE;
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    AST_HDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_HDR) |=> (state == CAP_DATA)); // R2
    AST_WHOLE_WINDOW_ROOM: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_HDR) |-> (int'(level) + WIN_LEN + 1 <= FIFO_DEPTH)); // R5
    AST_DROP_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state != CAP_IDLE) |=> $stable(drop_count)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        trig_overflow |=> trig_overflow); // R4
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !fifo_empty) |=> rd_valid); // R6
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fifo_empty) |=> !rd_valid); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full)); // R7

endmodule

// File: tb/trig_window_capture_tb.sv
module trig_window_capture_tb_top;

    localparam int NCH     = 24;
    localparam int SMP_W   = 10;
    localparam int LAT     = 212;
    localparam int WIN     = 4;
    localparam int FDEPTH  = 30;
    localparam int SEQ_W   = 12;
    localparam int DROP_W  = 8;
    localparam int WORD_W  = NCH * SMP_W;
    localparam int OUT_W   = WORD_W + 1;
    localparam int PRE     = WIN / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WORD_W-1:0] smp_data = '0;
    logic              trig_accept = 1'b0;
    logic              rd_en = 1'b0;
    logic [OUT_W-1:0]  rd_data;
    logic              rd_valid, fifo_empty, fifo_full, trig_overflow;
    logic [DROP_W-1:0] drop_count;

    int n_chk = 0;
    int n_bad = 0;
    int nk = 0;
    int kshown = 0;
    int seq_model = 0;
    int cyc = 0;
    logic [OUT_W-1:0] exp_q [$];

    always #5 clk = ~clk;

    trig_window_capture #(
        .NCH(NCH), .SMP_W(SMP_W), .LATENCY(LAT), .WIN_LEN(WIN),
        .FIFO_DEPTH(FDEPTH), .PEND_DEPTH(2), .SEQ_W(SEQ_W), .DROP_W(DROP_W)
    ) dut_i (
        .clk(clk), .rst(rst), .smp_data(smp_data), .trig_accept(trig_accept),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .trig_overflow(trig_overflow), .drop_count(drop_count)
    );

    function automatic logic [WORD_W-1:0] mk(input int k);
        logic [WORD_W-1:0] w;
        for (int c = 0; c < NCH; c++)
            w[c*SMP_W +: SMP_W] = SMP_W'((k * 13 + c * 71 + 5) & 1023);
        return w;
    endfunction

    // sample driver: a new sample every clock
    always @(negedge clk) begin
        smp_data = mk(nk);
        kshown   = nk;
        nk       = nk + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected word: actual %h expected none", rd_data);
            end else begin
                logic [OUT_W-1:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL R1/R2/R3 window word: actual %h expected %h", rd_data, e);
                end
            end
        end
    end

    // driver: n accept cycles; the first nq are queued, stored if store=1
    task automatic fire(input int n, input int nq, input bit store);
        @(negedge clk); #1;
        trig_accept = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (i < nq) begin
                if (store) begin
                    exp_q.push_back({1'b1, {(WORD_W - SEQ_W){1'b0}}, SEQ_W'(seq_model)});
                    for (int w = 0; w < WIN; w++)
                        exp_q.push_back({1'b0, mk(kshown - LAT - PRE + w)});
                end
                seq_model++;
            end
            @(negedge clk); #1;
        end
        trig_accept = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk); #1;
        while (!fifo_empty) begin
            rd_en = 1'b1;
            @(negedge clk); #1;
        end
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(fifo_empty == 1'b1, "R8", "empty after reset", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R8", "full after reset", fifo_full, 0);
        chk(trig_overflow == 1'b0, "R8", "overflow after reset", trig_overflow, 0);
        chk(drop_count == '0, "R8", "drop count after reset", drop_count, 0);
        chk(rd_valid == 1'b0, "R8", "rd_valid after reset", rd_valid, 0);
        #1 rst = 1'b0;
        repeat (260) @(negedge clk);

        // R1 R2 R3: single window
        fire(1, 1, 1);
        repeat (20) @(negedge clk);
        chk(fifo_empty == 1'b0, "R7", "not empty with a window", fifo_empty, 0);
        drain();

        // R4: three back-to-back accepts fit the pending queue
        fire(3, 3, 1);
        repeat (30) @(negedge clk);
        chk(trig_overflow == 1'b0, "R4", "no overflow for 3 accepts", trig_overflow, 0);
        drain();

        // R4: fourth back-to-back accept is lost
        fire(4, 3, 1);
        repeat (30) @(negedge clk);
        chk(trig_overflow == 1'b1, "R4", "overflow for 4 accepts", trig_overflow, 1);
        drain();

        // R6: read strobe while empty
        @(negedge clk); #1 rd_en = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R6", "rd_valid on empty read", rd_valid, 0);
        chk(fifo_empty == 1'b1, "R6", "still empty", fifo_empty, 1);
        #1 rd_en = 1'b0;

        // R5 R7: fill exactly six windows with no reads
        for (int i = 0; i < 6; i++) begin
            fire(1, 1, 1);
            repeat (8) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(fifo_full == 1'b1, "R7", "full after six windows", fifo_full, 1);
        chk(drop_count == 8'd0, "R5", "no drops yet", drop_count, 0);

        fire(1, 1, 0);
        repeat (10) @(negedge clk);
        chk(drop_count == 8'd1, "R5", "drop on full", drop_count, 1);
        chk(fifo_full == 1'b1, "R5", "nothing partial written", fifo_full, 1);

        @(negedge clk); #1 rd_en = 1'b1;
        @(negedge clk); #1 rd_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(fifo_full == 1'b0, "R7", "not full after one read", fifo_full, 0);

        fire(1, 1, 0);
        repeat (10) @(negedge clk);
        chk(drop_count == 8'd2, "R5", "drop with one free word", drop_count, 2);

        drain();
        chk(fifo_empty == 1'b1, "R7", "empty after drain", fifo_empty, 1);

        // R3: sequence gap after the two drops
        fire(1, 1, 1);
        repeat (20) @(negedge clk);
        drain();

        chk(exp_q.size() == 0, "R1", "all expected words seen", exp_q.size(), 0);
        chk(trig_overflow == 1'b1, "R4", "overflow stays set", trig_overflow, 1);
        finish_run();
    end

endmodule